// File: doc/BRIEF.md
# Lookahead Up/Down Counter

This block is a synchronous binary counter that steps up or down by one on every enabled clock edge. A direction input picks the way it counts. The width is a parameter and defaults to eight bits. Each bit decides whether to flip from two qualifier terms that are worked out in parallel: "every bit below me is one" and "every bit below me is zero". No toggle signal is passed from one stage to the next, so the decision logic for the top bit is as shallow as a wide AND allows, and it does not grow with a chain of stages.

A terminal-count output flags the last value before the count wraps in the selected direction. Together with the enable input, this lets several counters be chained or lets a loop detect its end. Reset is synchronous and clears the count.

Top module: `updn_lookahead_counter`

## Requirements
- R1: A synchronous reset (rst_i high at a rising edge) sets count_o to zero, whatever the enable is.
- R2: With en_i low and rst_i low, count_o keeps its value across the clock edge.
- R3: With en_i high and up_i high (1 = count up), count_o becomes count_o + 1 modulo 2^W on the next edge. A bit above bit 0 flips only when every lower bit is 1.
- R4: With en_i high and up_i low (0 = count down), count_o becomes count_o − 1 modulo 2^W on the next edge. A bit above bit 0 flips only when every lower bit is 0.
- R5: Bit 0 flips on every enabled edge, in either direction.
- R6: Counting up from 0x7F gives 0x80, and counting down from 0x80 gives 0x7F. All bits change on the same edge.
- R7: Counting up wraps from all ones to zero, and counting down wraps from zero to all ones.
- R8: tc_o is a combinational flag. It is 1 exactly when count_o is all ones and up_i is 1, or when count_o is all zeros and up_i is 0. It does not depend on en_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state updates on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Count enable, active high |
| up_i | input | 1 | Direction: 1 up, 0 down |
| count_o | output | W (8) | Current count |
| tc_o | output | 1 | Terminal count for the current direction |

## Verification
The bench drives long random runs that mix enable, direction and occasional resets, so every step is compared with a modular plus-or-minus-one model. Directed cases hit the carry boundaries: 0x7F going up, 0x80 going down, and the wraps at 0xFF and 0x00. Only these cases separate a correct lookahead from one that looks at too few lower bits. Flipping the direction while sitting at all ones or all zeros shows whether tc_o follows up_i rather than the last step taken. Holds with enable low show that nothing moves when the counter is idle.

// File: rtl/updn_pkg.sv
package updn_pkg;
  localparam int unsigned CNT_W = 8;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  function automatic logic all_ones_below(input logic [CNT_W-1:0] v, input int unsigned k);
    logic r;
    r = 1'b1;
    for (int unsigned j = 0; j < CNT_W; j++)
      if (j < k) r = r & v[j];
    return r;
  endfunction

  function automatic logic all_zeros_below(input logic [CNT_W-1:0] v, input int unsigned k);
    logic r;
    r = 1'b1;
    for (int unsigned j = 0; j < CNT_W; j++)
      if (j < k) r = r & ~v[j];
    return r;
  endfunction
endpackage

// File: rtl/updn_lookahead_terms.sv
module updn_lookahead_terms #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] ones_below_o,
  output logic [W-1:0] zeros_below_o
);
  // Each term is a direct AND of the lower bits; no term feeds another.
  generate
    for (genvar k = 0; k < W; k++) begin : g_term
      if (k == 0) begin : g_lsb
        assign ones_below_o[k]  = 1'b1;
        assign zeros_below_o[k] = 1'b1;
      end else begin : g_upper
        assign ones_below_o[k]  = &cnt_i[k-1:0];
        assign zeros_below_o[k] = ~(|cnt_i[k-1:0]);
      end
    end
  endgenerate
endmodule

// File: rtl/updn_toggle_sel.sv
module updn_toggle_sel #(
  parameter int unsigned W = 8
) (
  input  logic         en_i,
  input  logic         up_i,
  input  logic [W-1:0] ones_below_i,
  input  logic [W-1:0] zeros_below_i,
  output logic [W-1:0] toggle_o
);
  generate
    for (genvar k = 0; k < W; k++) begin : g_sel
      assign toggle_o[k] = en_i & (up_i ? ones_below_i[k] : zeros_below_i[k]);
    end
  endgenerate
endmodule

// File: rtl/updn_state_reg.sv
module updn_state_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] toggle_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) q_o <= '0;
    else       q_o <= q_o ^ toggle_i;
  end
endmodule

// File: rtl/updn_lookahead_counter.sv
module updn_lookahead_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  input  logic         up_i,
  output logic [W-1:0] count_o,
  output logic         tc_o
);
  localparam int unsigned TOP = W - 1;

  logic [W-1:0] ones_below;
  logic [W-1:0] zeros_below;
  logic [W-1:0] toggle_vec;
  logic         all_ones;
  logic         all_zeros;

  updn_lookahead_terms #(.W(W)) u_terms (
    .cnt_i        (count_o),
    .ones_below_o (ones_below),
    .zeros_below_o(zeros_below)
  );

  updn_toggle_sel #(.W(W)) u_sel (
    .en_i         (en_i),
    .up_i         (up_i),
    .ones_below_i (ones_below),
    .zeros_below_i(zeros_below),
    .toggle_o     (toggle_vec)
  );

  updn_state_reg #(.W(W)) u_reg (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .toggle_i(toggle_vec),
    .q_o     (count_o)
  );

  // Terminal terms reuse the top-bit lookahead terms.
  assign all_ones  = ones_below[TOP] & count_o[TOP];
  assign all_zeros = zeros_below[TOP] & ~count_o[TOP];
  assign tc_o      = up_i ? all_ones : all_zeros;
endmodule

// File: rtl/updn_lookahead_counter_chk.sv
module updn_lookahead_counter_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         en_i,
  input logic         up_i,
  input logic [W-1:0] count_o,
  input logic         tc_o,
  input logic [W-1:0] toggle_vec
);
  logic seen_edge;
  always_ff @(posedge clk_i) seen_edge <= 1'b1;

  p_reset_clears_r1: assert property (@(posedge clk_i) seen_edge && rst_i |=> count_o == '0);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i || !seen_edge)
    !en_i |=> $stable(count_o));
  p_up_step_r3: assert property (@(posedge clk_i) disable iff (rst_i || !seen_edge)
    en_i && up_i |=> count_o == W'($past(count_o) + 1'b1));
  p_down_step_r4: assert property (@(posedge clk_i) disable iff (rst_i || !seen_edge)
    en_i && !up_i |=> count_o == W'($past(count_o) - 1'b1));
  p_lsb_flips_r5: assert property (@(posedge clk_i) disable iff (rst_i || !seen_edge)
    en_i |=> count_o[0] != $past(count_o[0]));
  p_no_toggle_idle_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |-> toggle_vec == '0);
  p_wrap_up_r7: assert property (@(posedge clk_i) disable iff (rst_i || !seen_edge)
    en_i && up_i && (&count_o) |=> count_o == '0);
  p_tc_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    tc_o == (up_i ? (&count_o) : (count_o == '0)));
endmodule

bind updn_lookahead_counter updn_lookahead_counter_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .up_i(up_i),
  .count_o(count_o), .tc_o(tc_o), .toggle_vec(toggle_vec)
);

// File: tb/tb_updn_lookahead_counter.sv
`timescale 1ns/1ps
module tb_updn_lookahead_counter;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_i = 1'b1, en_i = 1'b0, up_i = 1'b1;
  logic [W-1:0] count_o;
  logic tc_o;
  int total = 0, bad = 0;
  logic [W-1:0] model = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  updn_lookahead_counter #(.W(W)) dut (
    .clk_i(clk), .rst_i(rst_i), .en_i(en_i), .up_i(up_i),
    .count_o(count_o), .tc_o(tc_o)
  );

  function automatic logic [W-1:0] next_val(logic [W-1:0] c, logic r, logic e, logic u);
    if (r) return '0;
    if (!e) return c;
    return u ? W'(c + 1) : W'(c - 1);
  endfunction

  function automatic logic exp_tc(logic [W-1:0] c, logic u);
    return u ? (c == {W{1'b1}}) : (c == '0);
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle; compare count and tc after the edge.
  task automatic step(logic r, logic e, logic u, string req);
    rst_i = r; en_i = e; up_i = u;
    #1;
    check({req, "/tc R8"}, W'(tc_o), W'(exp_tc(model, u)));
    @(posedge clk);
    model = next_val(model, r, e, u);
    #2;
    check(req, count_o, model);
  endtask

  task automatic goto_val(logic [W-1:0] v);
    step(1'b1, 1'b0, 1'b1, "R1");
    for (int i = 0; i < int'(v); i++) step(1'b0, 1'b1, 1'b1, "R3");
  endtask

  initial begin
    @(posedge clk); #2;
    check("R1 reset", count_o, '0);
    step(1'b0, 1'b0, 1'b1, "R2 hold at zero");
    step(1'b0, 1'b1, 1'b0, "R7 wrap down");
    check("R7 all ones", count_o, 8'hFF);
    step(1'b0, 1'b0, 1'b0, "R2 hold");
    step(1'b0, 1'b1, 1'b1, "R7 wrap up");
    check("R7 zero", count_o, 8'h00);
    goto_val(8'h7F);
    step(1'b0, 1'b1, 1'b1, "R6 up 7F");
    check("R6 80", count_o, 8'h80);
    step(1'b0, 1'b1, 1'b0, "R6 down 80");
    check("R6 7F", count_o, 8'h7F);
    step(1'b0, 1'b1, 1'b1, "R5 lsb");
    step(1'b0, 1'b1, 1'b0, "R4 down");
    step(1'b1, 1'b1, 1'b1, "R1 reset while enabled");
    for (int i = 0; i < 3000; i++) begin
      logic r, e, u;
      r = ($urandom % 50) == 0;
      e = ($urandom % 4) != 0;
      u = ($urandom % 2) != 0;
      step(r, e, u, u ? "R3 random" : "R4 random");
    end
    done = 1'b1;
  end

  initial begin
    void'($urandom(32'd1234));
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule